// File: doc/BRIEF.md
# Wiper Register Command Engine

This block carries out already-decoded commands for a two-channel digital wiper controller. Each channel owns one 6-bit volatile wiper code, which drives the tap selection of an external resistor ladder, and a bank of four 6-bit nonvolatile slots. A serial front end (outside this block) hands over a 4-bit opcode, a channel select, a slot select and the command's data byte on a one-cycle strobe, and separately signals the end of the bus transaction with a one-cycle stop strobe.

Commands read or write a wiper code, read or write a slot, copy a slot into a wiper, copy a wiper into a slot, copy one slot index into both wipers, copy both wipers into one slot index, and step a wiper up or down by one tap. Wiper changes are immediate. Any command that targets a slot is only staged: the storage is updated when the stop strobe arrives, and a program timer then holds the block busy for a fixed number of cycles. After reset the block spends one cycle copying slot 0 of each channel into that channel's wiper.

The controller is a four-state machine. LOAD (entered by reset) always moves to IDLE on the next cycle. IDLE accepts commands; a slot-targeting command moves it to ARMED. ARMED waits for the stop strobe and then moves to PROG, committing the staged values. PROG stays until the program timer expires and then returns to IDLE.

Top module: `wiper_cmd_engine`

## Requirements
- R1: While reset is held and for the single LOAD cycle after it, busy is 1 and rd_valid is 0; at the end of LOAD each wiper equals slot 0 of its own channel and busy returns to 0.
- R2: Opcode 4'b1010 sets the wiper chosen by cmd_pot (0 = wiper0, 1 = wiper1) to cmd_data[5:0] one cycle after the strobe; the other wiper is unchanged.
- R3: Opcode 4'b1001 (read wiper cmd_pot) and 4'b1011 (read slot cmd_slot of channel cmd_pot) pulse rd_valid for one cycle after the strobe with rd_data = {2'b00, value}.
- R4: Opcode 4'b1100 stages cmd_data[5:0] for slot cmd_slot (00 = slot 0 .. 11 = slot 3) of channel cmd_pot; the slot holds the new value once the stop strobe has been seen.
- R5: Opcode 4'b1101 copies slot cmd_slot of channel cmd_pot into that channel's wiper one cycle after the strobe, without busy.
- R6: Opcode 4'b1110 stages the wiper of channel cmd_pot, as it was at the strobe, for slot cmd_slot of the same channel.
- R7: Opcode 4'b0001 copies slot cmd_slot of each channel into that channel's wiper in the same cycle.
- R8: Opcode 4'b1000 stages both wipers for slot cmd_slot of their own channels.
- R9: A stop strobe in ARMED makes busy 1 for exactly PROG_CYCLES cycles, starting the cycle after the stop; a stop strobe with nothing staged leaves busy at 0.
- R10: Command strobes that arrive in ARMED, PROG or LOAD change no wiper, no slot, and produce no rd_valid.
- R11: Opcode 4'b0010 moves the chosen wiper one step up when cmd_data[0] is 1 and one step down when it is 0, holding at 63 and at 0.
- R12: Any other opcode changes no wiper or slot and produces no rd_valid.
- R13: rd_valid is never 1 except the cycle after an accepted read opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is present |
| cmd_op | input | 4 | Command opcode |
| cmd_pot | input | 1 | Channel select |
| cmd_slot | input | 2 | Nonvolatile slot select |
| cmd_data | input | 8 | Data byte of the command |
| stop_seen | input | 1 | One-cycle strobe: bus stop condition |
| wiper0 | output | 6 | Wiper code of channel 0 |
| wiper1 | output | 6 | Wiper code of channel 1 |
| rd_data | output | 8 | Read-back value, zero-extended |
| rd_valid | output | 1 | rd_data is valid this cycle |
| busy | output | 1 | LOAD or program cycle in progress |

## Verification
A seeded random mix of all nine opcodes plus undefined ones, with random channel, slot and data fields, is run against a bench model of both wipers and all eight slots, so a swapped channel, a wrong slot index or a global command hitting one channel only shows as a mismatch on a later read or wiper value. Stop strobes are sent both with and without staged writes, which separates a correct busy window length from a spurious one. Directed cases step a wiper against 63 and 0, send commands while ARMED and while PROG to show they are dropped, and reset after programming slot 0 to tell the power-up copy from a reset to zero.

// File: rtl/wcmd_pkg.sv
package wcmd_pkg;
    localparam int CHANS    = 2;
    localparam int SLOTS    = 4;
    localparam int CODE_W   = 6;
    localparam int BYTE_W   = 8;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    localparam logic [3:0] OP_GDR2W = 4'b0001;
    localparam logic [3:0] OP_STEP  = 4'b0010;
    localparam logic [3:0] OP_GW2DR = 4'b1000;
    localparam logic [3:0] OP_RDW   = 4'b1001;
    localparam logic [3:0] OP_WRW   = 4'b1010;
    localparam logic [3:0] OP_RDS   = 4'b1011;
    localparam logic [3:0] OP_WRS   = 4'b1100;
    localparam logic [3:0] OP_S2W   = 4'b1101;
    localparam logic [3:0] OP_W2S   = 4'b1110;

    typedef enum logic [1:0] {
        S_LOAD,
        S_IDLE,
        S_ARMED,
        S_PROG
    } state_t;

    typedef enum logic [3:0] {
        K_NONE,
        K_RD_WIPER,
        K_WR_WIPER,
        K_RD_SLOT,
        K_WR_SLOT,
        K_SLOT_TO_WIPER,
        K_WIPER_TO_SLOT,
        K_ALL_SLOT_TO_WIPER,
        K_ALL_WIPER_TO_SLOT,
        K_STEP
    } kind_t;
endpackage

// File: rtl/wcmd_decode.sv
module wcmd_decode
    import wcmd_pkg::*;
(
    input  logic [3:0] op,
    output kind_t      kind,
    output logic       stages_nv
);
    always_comb begin
        unique case (op)
            OP_RDW:   kind = K_RD_WIPER;
            OP_WRW:   kind = K_WR_WIPER;
            OP_RDS:   kind = K_RD_SLOT;
            OP_WRS:   kind = K_WR_SLOT;
            OP_S2W:   kind = K_SLOT_TO_WIPER;
            OP_W2S:   kind = K_WIPER_TO_SLOT;
            OP_GDR2W: kind = K_ALL_SLOT_TO_WIPER;
            OP_GW2DR: kind = K_ALL_WIPER_TO_SLOT;
            OP_STEP:  kind = K_STEP;
            default:  kind = K_NONE;
        endcase
    end

    assign stages_nv = (kind == K_WR_SLOT) || (kind == K_WIPER_TO_SLOT) ||
                       (kind == K_ALL_WIPER_TO_SLOT);
endmodule

// File: rtl/wcmd_nvbank.sv
module wcmd_nvbank
    import wcmd_pkg::*;
(
    input  logic                                    clk,
    input  logic [CHANS-1:0]                        we,
    input  logic [SLOT_W-1:0]                       wslot,
    input  logic [CHANS-1:0][CODE_W-1:0]            wval,
    output logic [CHANS-1:0][SLOTS-1:0][CODE_W-1:0] q
);
    // Storage survives rst_n on purpose: it stands for nonvolatile cells.
    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (we[c] && (wslot == SLOT_W'(s))) begin
                    q[c][s] <= wval[c];
                end
            end
        end
    end
endmodule

// File: rtl/wcmd_prog_timer.sv
module wcmd_prog_timer #(
    parameter int COUNT = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [CW-1:0] cnt;
    logic          running;

    assign done = running && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= CW'(COUNT - 1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wiper_cmd_engine.sv
module wiper_cmd_engine
    import wcmd_pkg::*;
#(
    parameter int PROG_CYCLES = 250000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_op,
    input  logic        cmd_pot,
    input  logic [1:0]  cmd_slot,
    input  logic [7:0]  cmd_data,
    input  logic        stop_seen,
    output logic [5:0]  wiper0,
    output logic [5:0]  wiper1,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        busy
);
    state_t state, nstate;
    kind_t  kind;
    logic   stages_nv;
    logic   take;
    logic   commit;
    logic   prog_done;

    logic [CHANS-1:0][CODE_W-1:0]            wip_q;
    logic [CHANS-1:0][SLOTS-1:0][CODE_W-1:0] nv_q;
    logic [CHANS-1:0]                        pend_we;
    logic [SLOT_W-1:0]                       pend_slot;
    logic [CHANS-1:0][CODE_W-1:0]            pend_val;
    logic [CODE_W-1:0]                       sel_wip;
    logic [CODE_W-1:0]                       sel_slot;

    wcmd_decode u_dec (
        .op        (cmd_op),
        .kind      (kind),
        .stages_nv (stages_nv)
    );

    wcmd_nvbank u_bank (
        .clk   (clk),
        .we    (commit ? pend_we : '0),
        .wslot (pend_slot),
        .wval  (pend_val),
        .q     (nv_q)
    );

    wcmd_prog_timer #(.COUNT(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .done  (prog_done)
    );

    assign take     = cmd_valid && (state == S_IDLE);
    assign commit   = stop_seen && (state == S_ARMED);
    assign sel_wip  = wip_q[cmd_pot];
    assign sel_slot = nv_q[cmd_pot][cmd_slot];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_LOAD;
        else        state <= nstate;
    end

    // Next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_LOAD:  nstate = S_IDLE;
            S_IDLE:  if (take && stages_nv) nstate = S_ARMED;
            S_ARMED: if (stop_seen) nstate = S_PROG;
            S_PROG:  if (prog_done) nstate = S_IDLE;
            default: nstate = S_LOAD;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wip_q     <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            pend_we   <= '0;
            pend_slot <= '0;
            pend_val  <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (state)
                S_LOAD: begin
                    for (int c = 0; c < CHANS; c++) wip_q[c] <= nv_q[c][0];
                end
                S_IDLE: begin
                    if (take) begin
                        pend_slot <= cmd_slot;
                        pend_we   <= '0;
                        unique case (kind)
                            K_RD_WIPER: begin
                                rd_valid <= 1'b1;
                                rd_data  <= BYTE_W'(sel_wip);
                            end
                            K_RD_SLOT: begin
                                rd_valid <= 1'b1;
                                rd_data  <= BYTE_W'(sel_slot);
                            end
                            K_WR_WIPER: wip_q[cmd_pot] <= cmd_data[CODE_W-1:0];
                            K_SLOT_TO_WIPER: wip_q[cmd_pot] <= sel_slot;
                            K_ALL_SLOT_TO_WIPER: begin
                                for (int c = 0; c < CHANS; c++) wip_q[c] <= nv_q[c][cmd_slot];
                            end
                            K_WR_SLOT: begin
                                pend_we[cmd_pot]  <= 1'b1;
                                pend_val[cmd_pot] <= cmd_data[CODE_W-1:0];
                            end
                            K_WIPER_TO_SLOT: begin
                                pend_we[cmd_pot]  <= 1'b1;
                                pend_val[cmd_pot] <= sel_wip;
                            end
                            K_ALL_WIPER_TO_SLOT: begin
                                pend_we  <= '1;
                                pend_val <= wip_q;
                            end
                            K_STEP: begin
                                if (cmd_data[0] && (sel_wip != CODE_MAX))
                                    wip_q[cmd_pot] <= sel_wip + 1'b1;
                                else if (!cmd_data[0] && (sel_wip != '0))
                                    wip_q[cmd_pot] <= sel_wip - 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                S_ARMED: if (stop_seen) pend_we <= '0;
                S_PROG: ;
                default: ;
            endcase
        end
    end

    assign wiper0 = wip_q[0];
    assign wiper1 = wip_q[1];
    assign busy   = (state == S_LOAD) || (state == S_PROG);
endmodule

// File: rtl/wcmd_checker.sv
module wcmd_checker
    import wcmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       cmd_pot,
    input logic [7:0] cmd_data,
    input logic       stop_seen,
    input logic [5:0] wiper0,
    input logic [5:0] wiper1,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       busy,
    input state_t     st
);
    // R3
    rd_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[7:6] == 2'b00));

    // R13
    rd_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(cmd_valid) && ($past(st) == S_IDLE) &&
                      (($past(cmd_op) == OP_RDW) || ($past(cmd_op) == OP_RDS))));

    // R9
    stop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && (st == S_ARMED)) |=> busy);

    // R10
    prog_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PROG) |=> ($stable(wiper0) && $stable(wiper1) && !rd_valid));

    // R2
    other_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (st == S_IDLE) && (cmd_op == OP_WRW) && !cmd_pot) |=> $stable(wiper1));

    // R11
    step_sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (st == S_IDLE) && (cmd_op == OP_STEP) && !cmd_pot &&
         cmd_data[0] && (wiper0 == 6'd63)) |=> (wiper0 == 6'd63));

    // R11
    step_sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (st == S_IDLE) && (cmd_op == OP_STEP) && !cmd_pot &&
         !cmd_data[0] && (wiper0 == 6'd0)) |=> (wiper0 == 6'd0));
endmodule

bind wiper_cmd_engine wcmd_checker i_wcmd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_pot   (cmd_pot),
    .cmd_data  (cmd_data),
    .stop_seen (stop_seen),
    .wiper0    (wiper0),
    .wiper1    (wiper1),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .st        (state)
);

// File: tb/test_wiper_cmd_engine.sv
module test_wiper_cmd_engine;
    localparam int CLK_P = 10;
    localparam int PROG  = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic       cmd_pot = 1'b0;
    logic [1:0] cmd_slot = '0;
    logic [7:0] cmd_data = '0;
    logic       stop_seen = 1'b0;
    logic [5:0] wiper0, wiper1;
    logic [7:0] rd_data;
    logic       rd_valid, busy;

    int checks = 0;
    int fails  = 0;

    logic [5:0] m_nv [2][4];
    logic [5:0] m_w  [2];
    logic       p_we [2];
    logic [5:0] p_val[2];
    logic [1:0] p_slot;

    wiper_cmd_engine #(.PROG_CYCLES(PROG)) i_wiper_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_slot(cmd_slot), .cmd_data(cmd_data),
        .stop_seen(stop_seen), .wiper0(wiper0), .wiper1(wiper1),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [5:0] step_exp(input logic [5:0] v, input logic up);
        if (up) return (v == 6'd63) ? v : v + 6'd1;
        return (v == 6'd0) ? v : v - 6'd1;
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'b1001, 4'b1011: return "R3";
            4'b1010: return "R2";
            4'b1100: return "R4";
            4'b1101: return "R5";
            4'b1110: return "R6";
            4'b0001: return "R7";
            4'b1000: return "R8";
            4'b0010: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic issue(input logic [3:0] op, input logic p, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pot = p; cmd_slot = s; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [5:0] get_w(input int p);
        return (p == 0) ? wiper0 : wiper1;
    endfunction

    task automatic do_stop();
        int n;
        logic any;
        any = p_we[0] || p_we[1];
        @(negedge clk);
        stop_seen = 1'b1;
        @(negedge clk);
        stop_seen = 1'b0;
        if (any) begin
            for (int c = 0; c < 2; c++) if (p_we[c]) m_nv[c][p_slot] = p_val[c];
            p_we[0] = 1'b0; p_we[1] = 1'b0;
            n = 0;
            while (busy && n < PROG + 5) begin
                n++;
                @(negedge clk);
            end
            chk(n == PROG, "R9 busy length", n, PROG);
        end else begin
            chk(busy == 1'b0, "R9 idle stop", busy, 0);
        end
    endtask

    task automatic run_cmd(input logic [3:0] op, input logic p, input logic [1:0] s, input logic [7:0] d);
        logic [5:0] ew [2];
        logic       erv;
        logic [7:0] erd;
        string      rq;
        rq = req_of(op);
        ew[0] = m_w[0]; ew[1] = m_w[1];
        erv = 1'b0; erd = '0;
        p_slot = s;
        case (op)
            4'b1001: begin erv = 1'b1; erd = {2'b00, m_w[p]}; end
            4'b1011: begin erv = 1'b1; erd = {2'b00, m_nv[p][s]}; end
            4'b1010: ew[p] = d[5:0];
            4'b1100: begin p_we[p] = 1'b1; p_val[p] = d[5:0]; end
            4'b1101: ew[p] = m_nv[p][s];
            4'b1110: begin p_we[p] = 1'b1; p_val[p] = m_w[p]; end
            4'b0001: begin ew[0] = m_nv[0][s]; ew[1] = m_nv[1][s]; end
            4'b1000: begin
                p_we[0] = 1'b1; p_we[1] = 1'b1; p_val[0] = m_w[0]; p_val[1] = m_w[1];
            end
            4'b0010: ew[p] = step_exp(m_w[p], d[0]);
            default: ;
        endcase
        issue(op, p, s, d);
        chk(rd_valid == erv, {rq, " rd_valid"}, rd_valid, erv);
        if (erv) chk(rd_data == erd, {rq, " rd_data"}, rd_data, erd);
        chk(wiper0 == ew[0], {rq, " wiper0"}, wiper0, ew[0]);
        chk(wiper1 == ew[1], {rq, " wiper1"}, wiper1, ew[1]);
        m_w[0] = ew[0]; m_w[1] = ew[1];
        if (p_we[0] || p_we[1]) do_stop();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy in reset", busy, 1);
        chk(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after load", busy, 0);
    endtask

    // Watchdog
    initial begin
        #(CLK_P * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [3:0] ops [12];
        logic [3:0] op;
        logic [5:0] w_before;
        void'($urandom(32'h5EED_0421));
        ops = '{4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101, 4'b1110,
                4'b0001, 4'b1000, 4'b0010, 4'b0000, 4'b0111, 4'b1111};
        p_we[0] = 1'b0; p_we[1] = 1'b0; p_slot = '0;

        // R1: reset state
        #(CLK_P * 3);
        chk(busy == 1'b1, "R1 busy in reset", busy, 1);
        chk(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after load", busy, 0);

        // Bring wipers and all slots to known values (R2, R4)
        m_w[0] = wiper0; m_w[1] = wiper1;
        run_cmd(4'b1010, 1'b0, 2'd0, 8'hE5);
        run_cmd(4'b1010, 1'b1, 2'd3, 8'h1A);
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 4; s++)
                run_cmd(4'b1100, c[0], s[1:0], 8'(8'h40 + c * 16 + s * 5 + 3));
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 4; s++)
                run_cmd(4'b1011, c[0], s[1:0], 8'h00);

        // R1: power-up copies slot 0 into wipers
        do_reset();
        chk(wiper0 == m_nv[0][0], "R1 wiper0 from slot0", wiper0, m_nv[0][0]);
        chk(wiper1 == m_nv[1][0], "R1 wiper1 from slot0", wiper1, m_nv[1][0]);
        m_w[0] = m_nv[0][0]; m_w[1] = m_nv[1][0];

        // R11: saturation corners
        run_cmd(4'b1010, 1'b0, 2'd0, 8'h3F);
        run_cmd(4'b0010, 1'b0, 2'd0, 8'h01);
        run_cmd(4'b1010, 1'b1, 2'd0, 8'h00);
        run_cmd(4'b0010, 1'b1, 2'd0, 8'h00);
        run_cmd(4'b0010, 1'b1, 2'd0, 8'h01);

        // R10: commands while ARMED and while PROG are dropped
        w_before = m_w[0];
        p_slot = 2'd2; p_we[1] = 1'b1; p_val[1] = 6'd33;
        issue(4'b1100, 1'b1, 2'd2, 8'h21);
        issue(4'b1010, 1'b0, 2'd0, 8'h11);
        chk(wiper0 == w_before, "R10 write in ARMED", wiper0, w_before);
        issue(4'b1001, 1'b0, 2'd0, 8'h00);
        chk(rd_valid == 1'b0, "R10 read in ARMED", rd_valid, 0);
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
        m_nv[1][2] = 6'd33; p_we[1] = 1'b0;
        issue(4'b0001, 1'b0, 2'd2, 8'h00);
        chk(wiper0 == w_before, "R10 global in PROG", wiper0, w_before);
        issue(4'b1011, 1'b1, 2'd2, 8'h00);
        chk(rd_valid == 1'b0, "R10 read in PROG", rd_valid, 0);
        while (busy) @(negedge clk);
        run_cmd(4'b1011, 1'b1, 2'd2, 8'h00);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            op = ops[$urandom % 12];
            run_cmd(op, 1'($urandom), 2'($urandom), 8'($urandom));
            if (($urandom % 6) == 0) do_stop();
            if (($urandom % 5) == 0)
                run_cmd(4'b1011, 1'($urandom), 2'($urandom), 8'h00);
        end

        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 4; s++)
                run_cmd(4'b1011, c[0], s[1:0], 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule